// File: doc/BRIEF.md
# Reconfigurable Packed Lane Multiply-Accumulate Unit

This block is a 128-bit packed integer datapath. It treats three input vectors as arrays of independent lanes. In every lane it multiplies one element of the first source by the matching element of the second source and keeps only the low lane-width bits of that product. It then adds that truncated product to the matching accumulator element, or subtracts it from that element. The new vector comes out one clock later, together with a valid strobe.

The lane size can be changed on every operation: 8, 16 or 32 bits. The active width can also be changed per operation: only the low 64 bits, or all 128 bits. Elements are multiplied as unsigned numbers. Because only the low lane-width bits are kept, the result is the same whether the software treats the elements as signed or unsigned. The block produces no flags. The one exception is an indication that the lane-size code was the reserved one.

Top module: `simd_mac_top`

## Requirements
- R1: `lane_sel` picks the element width: 2'b00 gives 8 bits, 2'b01 gives 16 bits and 2'b10 gives 32 bits. Element k of every operand and of the result occupies bits [k*W +: W], where W is the element width.
- R2: With `sub_mode` low, each lane of the result equals (acc + ((a*b) mod 2^W)) mod 2^W, with a and b taken as unsigned.
- R3: With `sub_mode` high, each lane of the result equals (acc - ((a*b) mod 2^W)) mod 2^W.
- R4: No carry or borrow passes from one lane into the next, even when every operand bit is one.
- R5: With `full_width` low, lanes in bits 63:0 are computed as in R2/R3, and result bits 127:64 are zero.
- R6: With `full_width` high, all lanes across bits 127:0 are computed.
- R7: With `lane_sel` = 2'b11 (reserved), the result is all zeros and `cfg_illegal` is high in the same cycle as `out_valid`. Otherwise `cfg_illegal` is low for that result.
- R8: `out_valid` is high exactly one clock after a cycle with `in_valid` high and is low otherwise. `result` and `cfg_illegal` change only in response to accepted inputs.
- R9: A synchronous active-high `rst` clears `out_valid`, `result` and `cfg_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| lane_sel | input | 2 | Element width code (8/16/32, 2'b11 reserved) |
| full_width | input | 1 | 1: process 128 bits, 0: low 64 bits only |
| sub_mode | input | 1 | 1: accumulator minus product, 0: accumulator plus product |
| src_a | input | 128 | First multiplicand vector |
| src_b | input | 128 | Second multiplicand vector |
| acc_in | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 128 | Packed result vector |
| cfg_illegal | output | 1 | The accepted operation used the reserved lane code |

## Verification
The assertions check several properties on every cycle. They check the one-cycle valid latency. They check that the result holds between accepted operations. They check the zero upper half in narrow mode and the all-zero result for the reserved code. They also check that each lane's sum and difference outputs differ by exactly twice the truncated product. The actual lane arithmetic, the placement of elements within the vector, and the absence of carries at lane boundaries can only be shown by the bench. It sweeps every lane code, both widths and both modes with random, all-ones and all-zero operands, and it compares against an element-by-element model.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;

  localparam int VEC_W  = 128;
  localparam int HALF_W = VEC_W / 2;

  typedef enum logic [1:0] {
    LS_8    = 2'b00,
    LS_16   = 2'b01,
    LS_32   = 2'b10,
    LS_RSVD = 2'b11
  } lane_size_e;

  function automatic int lane_bits(input lane_size_e sz);
    case (sz)
      LS_8:    return 8;
      LS_16:   return 16;
      LS_32:   return 32;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/simd_mac_bank.sv
module simd_mac_bank #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] acc_in,
  input  logic             sub_mode,
  output logic [VEC_W-1:0] bank_res
);

  localparam int N_LANES = VEC_W / LANE_W;

  // Low LANE_W bits of the unsigned product; the context width truncates it.
  function automatic logic [LANE_W-1:0] mul_lo(input logic [LANE_W-1:0] x,
                                               input logic [LANE_W-1:0] y);
    return x * y;
  endfunction

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    logic [LANE_W-1:0] ea, eb, ec;
    logic [LANE_W-1:0] prod;
    logic [LANE_W-1:0] lane_sum;
    logic [LANE_W-1:0] lane_diff;

    assign ea        = src_a[k*LANE_W +: LANE_W];
    assign eb        = src_b[k*LANE_W +: LANE_W];
    assign ec        = acc_in[k*LANE_W +: LANE_W];
    assign prod      = mul_lo(ea, eb);
    assign lane_sum  = ec + prod;
    assign lane_diff = ec - prod;
    assign bank_res[k*LANE_W +: LANE_W] = sub_mode ? lane_diff : lane_sum;

    // R2/R3: add and subtract paths must differ by twice the product.
    always_comb begin
      p_add_sub_gap_r3: assert ((lane_sum - lane_diff) == (prod + prod))
        else $error("lane %0d sum/diff gap mismatch", k);
    end
  end

endmodule

// File: rtl/simd_mac_select.sv
module simd_mac_select
  import simd_mac_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] res8,
  input  logic [VEC_W-1:0] res16,
  input  logic [VEC_W-1:0] res32,
  input  lane_size_e       lane_sel,
  input  logic             full_width,
  output logic [VEC_W-1:0] sel_res,
  output logic             illegal
);

  localparam int HALF = VEC_W / 2;

  logic [VEC_W-1:0] picked;

  always_comb begin
    illegal = 1'b0;
    case (lane_sel)
      LS_8:    picked = res8;
      LS_16:   picked = res16;
      LS_32:   picked = res32;
      default: begin
        picked  = '0;
        illegal = 1'b1;
      end
    endcase
  end

  assign sel_res = full_width ? picked : {{HALF{1'b0}}, picked[HALF-1:0]};

endmodule

// File: rtl/simd_mac_top.sv
module simd_mac_top
  import simd_mac_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   lane_sel,
  input  logic         full_width,
  input  logic         sub_mode,
  input  logic [127:0] src_a,
  input  logic [127:0] src_b,
  input  logic [127:0] acc_in,
  output logic         out_valid,
  output logic [127:0] result,
  output logic         cfg_illegal
);

  localparam int N_SIZES = 3;

  logic [VEC_W-1:0] bank_res [N_SIZES];
  logic [VEC_W-1:0] comb_res;
  logic             comb_illegal;
  logic             wide_q;
  lane_size_e       size_e;

  assign size_e = lane_size_e'(lane_sel);

  for (genvar g = 0; g < N_SIZES; g++) begin : g_bank
    simd_mac_bank #(
      .VEC_W  (VEC_W),
      .LANE_W (8 << g)
    ) u_bank (
      .src_a    (src_a),
      .src_b    (src_b),
      .acc_in   (acc_in),
      .sub_mode (sub_mode),
      .bank_res (bank_res[g])
    );
  end

  simd_mac_select #(.VEC_W(VEC_W)) u_sel (
    .res8       (bank_res[0]),
    .res16      (bank_res[1]),
    .res32      (bank_res[2]),
    .lane_sel   (size_e),
    .full_width (full_width),
    .sel_res    (comb_res),
    .illegal    (comb_illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      cfg_illegal <= 1'b0;
      wide_q      <= 1'b1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result      <= comb_res;
        cfg_illegal <= comb_illegal;
        wide_q      <= full_width;
      end
    end
  end

  // R8: valid follows input valid by exactly one clock
  p_valid_latency_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: outputs hold when nothing is accepted
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(cfg_illegal)));
  // R5: narrow mode leaves the upper half zero
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wide_q) |-> (result[127:64] == '0));
  // R7: reserved lane code yields an all-zero result
  p_illegal_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_illegal) |-> (result == '0));

endmodule

// File: tb/simd_mac_top_test.sv
module simd_mac_top_test;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   lane_sel;
  logic         full_width;
  logic         sub_mode;
  logic [127:0] src_a, src_b, acc_in;
  logic         out_valid;
  logic [127:0] result;
  logic         cfg_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  simd_mac_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_sel(lane_sel),
    .full_width(full_width), .sub_mode(sub_mode), .src_a(src_a),
    .src_b(src_b), .acc_in(acc_in), .out_valid(out_valid),
    .result(result), .cfg_illegal(cfg_illegal)
  );

  // Element-by-element model computed with 64-bit arithmetic.
  function automatic logic [127:0] model(input logic [127:0] a, b, c,
                                         input logic [1:0] sz,
                                         input logic wide, sb);
    logic [127:0] r = '0;
    if (sz == 2'b11) return r;
    begin
      int w = 8 << sz;
      int n = (wide ? 128 : 64) / w;
      longint unsigned mask = (64'd1 << w) - 1;
      for (int k = 0; k < n; k++) begin
        longint unsigned ea = 64'((a >> (k*w))) & mask;
        longint unsigned eb = 64'((b >> (k*w))) & mask;
        longint unsigned ec = 64'((c >> (k*w))) & mask;
        longint unsigned p  = (ea * eb) & mask;
        longint unsigned v  = (sb ? (ec - p) : (ec + p)) & mask;
        r |= 128'(v) << (k*w);
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] a, b, c, input logic [1:0] sz,
                        input logic wide, sb, input string pat);
    logic [127:0] exp = model(a, b, c, sz, wide, sb);
    logic [127:0] held;
    string tag;
    @(negedge clk);
    src_a = a; src_b = b; acc_in = c; lane_sel = sz;
    full_width = wide; sub_mode = sb; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    src_a = ~a; src_b = ~b; acc_in = ~c;
    if (sz == 2'b11) tag = "R7";
    else if (!wide)  tag = sb ? "R1/R3/R4/R5" : "R1/R2/R4/R5";
    else             tag = sb ? "R1/R3/R4/R6" : "R1/R2/R4/R6";
    tag = {tag, " ", pat};
    check(out_valid === 1'b1, "R8 valid latency", 128'(out_valid), 128'd1);
    check(result === exp, tag, result, exp);
    check(cfg_illegal === (sz == 2'b11), "R7 illegal flag",
          128'(cfg_illegal), 128'(sz == 2'b11));
    held = result;
    @(negedge clk);
    check(out_valid === 1'b0 && result === held, "R8 hold/idle",
          result, held);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; lane_sel = 2'b00; full_width = 1'b1;
    sub_mode = 1'b0; src_a = '0; src_b = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid === 1'b0 && result === '0 && cfg_illegal === 1'b0,
          "R9 reset", result, 128'd0);
    rst = 1'b0;
    for (int sz = 0; sz < 4; sz++)
      for (int wd = 0; wd < 2; wd++)
        for (int sb = 0; sb < 2; sb++) begin
          for (int r = 0; r < 3; r++)
            run_op(rnd128(), rnd128(), rnd128(), 2'(sz), wd[0], sb[0], "random");
          run_op('1, '1, '1, 2'(sz), wd[0], sb[0], "all-ones");
          run_op('0, '0, '0, 2'(sz), wd[0], sb[0], "zeros");
          run_op('0, '0, '1, 2'(sz), wd[0], sb[0], "zero-product");
        end
    // R9: reset mid-stream clears a loaded result
    run_op('1, '1, '1, 2'b00, 1'b1, 1'b0, "pre-reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(out_valid === 1'b0 && result === '0 && cfg_illegal === 1'b0,
          "R9 reset after use", result, 128'd0);
    finish_up();
  end

endmodule